// File: doc/BRIEF.md
# Break-Framed UART Command Receiver

This block watches one asynchronous serial input and turns the characters on it into bytes and command packets. Each bit is oversampled sixteen times with a tick derived from the system clock, and the three samples around the bit centre are combined by majority vote. Ordinary characters carry odd parity and a stop bit; characters that fail either check are dropped and recorded in a sticky error flag.

At the fast rate a character that is low for the whole eleven-bit frame is taken as a break. A break raises no error, marks the start of a command, and the next three good characters are joined into a single 24-bit packet with a one-cycle valid strobe. At the slow rate no break is recognised and characters only appear as plain bytes. Interpreting the packet is left to the logic downstream.

Top module: `brk_uart_rx`

## Requirements
- R1: After reset all strobes are low, `byte_o` and `pkt_o` are zero and `err_sticky` is clear.
- R2: A character is a low start bit, eight data bits with bit 0 sent first, an odd parity bit (data plus parity hold an odd number of ones) and a high stop bit; a good character yields one `byte_vld` pulse with the data on `byte_o`.
- R3: Each bit is sampled 16 times and decided by majority of samples 7, 8 and 9; a low pulse shorter than a quarter bit on an idle line produces no output.
- R4: With `baud_fast` high, a frame low for all eleven bit times gives one `brk_o` pulse, no `byte_vld` and no error; the receiver then waits for the line to return high before looking for a new start bit.
- R5: After a break, the next three good characters give one `pkt_vld` pulse, first byte in `pkt_o[23:16]` and third in `pkt_o[7:0]`, in the same cycle as the third `byte_vld`; good characters with no break before them give bytes only.
- R6: A break that arrives while a packet is being collected discards the partial packet and starts collection afresh.
- R7: A character with a parity or stop error gives no `byte_vld`, sets `err_sticky`, and discards any packet being collected.
- R8: `err_sticky` stays set until `err_clr` is pulsed, which clears it.
- R9: With `baud_fast` low no break is recognised and no packet is produced; an all-low frame counts as a parity and stop error, and good characters appear as bytes.
- R10: The tick divider is round(CLK_HZ / (16 × baud)), the baud being FAST_BAUD when `baud_fast` is high and SLOW_BAUD when low; the select may change while the line is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input line, idle high |
| baud_fast | input | 1 | 1 selects the fast rate with break framing, 0 the slow rate |
| err_clr | input | 1 | Clears the sticky error flag |
| byte_o | output | 8 | Last good received byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_o` |
| pkt_o | output | 24 | Last completed command packet |
| pkt_vld | output | 1 | One-cycle strobe for `pkt_o` |
| brk_o | output | 1 | One-cycle strobe when a break is recognised |
| err_sticky | output | 1 | Set by a parity or stop error |

## Verification
The bench builds the receiver with CLK_HZ of 614400 and the default baud rates, so the divider becomes 4 clocks per tick at the fast rate and 32 at the slow rate. A fast bit then lasts 64 clocks and a slow bit 512, which lets whole packets, breaks in the middle of packets, errored frames and a round trip through the slow rate run in a few tens of thousands of cycles. The short divider also makes a two-tick glitch easy to place ahead of the majority samples.

// File: rtl/brk_uart_rx.sv
module brk_uart_rx #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int FAST_BAUD = 9600,
  parameter int SLOW_BAUD = 1200,
  parameter int OVS       = 16,
  parameter int BYTE_W    = 8,
  parameter int PKT_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rxd,
  input  logic                        baud_fast,
  input  logic                        err_clr,
  output logic [BYTE_W-1:0]           byte_o,
  output logic                        byte_vld,
  output logic [PKT_BYTES*BYTE_W-1:0] pkt_o,
  output logic                        pkt_vld,
  output logic                        brk_o,
  output logic                        err_sticky
);

  localparam int DIV_F = (CLK_HZ + FAST_BAUD*OVS/2) / (FAST_BAUD*OVS);
  localparam int DIV_S = (CLK_HZ + SLOW_BAUD*OVS/2) / (SLOW_BAUD*OVS);
  localparam int CW    = $clog2(DIV_S + 1);
  localparam int SW    = $clog2(OVS);
  localparam int MID   = OVS / 2;
  localparam int NBITS = BYTE_W + 3;
  localparam int BW    = $clog2(NBITS);
  localparam int PW    = PKT_BYTES * BYTE_W;
  localparam int KW    = $clog2(PKT_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_WAIT} st_t;

  st_t              st;
  logic [1:0]       sync;
  logic [CW-1:0]    tcnt;
  logic [SW-1:0]    sub;
  logic [BW-1:0]    bidx;
  logic [1:0]       smp;
  logic [NBITS-1:0] sh;
  logic [PW-1:0]    acc;
  logic [KW-1:0]    cnt;
  logic             armed;

  wire              rx     = sync[1];
  wire [CW-1:0]     tlim   = baud_fast ? CW'(DIV_F - 1) : CW'(DIV_S - 1);
  wire              tick   = tcnt >= tlim;
  wire              maj    = (smp[1] & smp[0]) | (smp[1] & rx) | (smp[0] & rx);
  wire              decide = tick && st == S_RX && sub == SW'(MID + 1);
  wire              last   = bidx == BW'(NBITS - 1);
  wire              fin    = decide && last;
  wire [NBITS-1:0]  fr     = {maj, sh[NBITS-1:1]};
  wire [BYTE_W-1:0] dat    = fr[BYTE_W:1];
  wire              is_brk = baud_fast && fr == '0;
  wire              bad    = !is_brk && (!(^fr[BYTE_W+1:1]) || !fr[NBITS-1]);
  wire              good   = !is_brk && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      tcnt <= '0;
      st   <= S_IDLE;
      sub  <= '0;
      bidx <= '0;
      smp  <= '0;
      sh   <= '0;
    end else begin
      sync <= {sync[0], rxd};
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx) begin
            st   <= S_RX;
            sub  <= '0;
            bidx <= '0;
          end
          S_RX: begin
            sub <= (sub == SW'(OVS - 1)) ? '0 : sub + 1'b1;
            if (sub == SW'(OVS - 1)) bidx <= bidx + 1'b1;
            if (sub == SW'(MID - 1) || sub == SW'(MID)) smp <= {smp[0], rx};
            if (sub == SW'(MID + 1)) begin
              sh <= fr;
              if (bidx == '0 && maj) st <= S_IDLE;
              else if (last)         st <= fr[NBITS-1] ? S_IDLE : S_WAIT;
            end
          end
          S_WAIT: if (rx) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o     <= '0;
      byte_vld   <= 1'b0;
      pkt_o      <= '0;
      pkt_vld    <= 1'b0;
      brk_o      <= 1'b0;
      err_sticky <= 1'b0;
      acc        <= '0;
      cnt        <= '0;
      armed      <= 1'b0;
    end else begin
      byte_vld <= fin && good;
      brk_o    <= fin && is_brk;
      pkt_vld  <= 1'b0;
      if (fin && good) byte_o <= dat;
      if (fin && bad)  err_sticky <= 1'b1;
      else if (err_clr) err_sticky <= 1'b0;
      if (fin && is_brk) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (fin && bad) begin
        armed <= 1'b0;
      end else if (fin && good && armed && baud_fast) begin
        acc <= {acc[PW-BYTE_W-1:0], dat};
        cnt <= cnt + 1'b1;
        if (cnt == KW'(PKT_BYTES - 1)) begin
          pkt_vld <= 1'b1;
          pkt_o   <= {acc[PW-BYTE_W-1:0], dat};
          armed   <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/brk_uart_rx_chk.sv
module brk_uart_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_fast,
  input logic err_clr,
  input logic byte_vld,
  input logic pkt_vld,
  input logic brk_o,
  input logic err_sticky,
  input logic fin
);

  p_byte_after_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(fin));

  p_brk_fast_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_o |-> $past(baud_fast));

  p_brk_no_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_vld, brk_o}));

  p_pkt_with_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> byte_vld);

  p_err_from_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> $past(fin));

  p_err_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  p_no_pkt_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_vld |-> $past(baud_fast));

endmodule

bind brk_uart_rx brk_uart_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .baud_fast  (baud_fast),
  .err_clr    (err_clr),
  .byte_vld   (byte_vld),
  .pkt_vld    (pkt_vld),
  .brk_o      (brk_o),
  .err_sticky (err_sticky),
  .fin        (fin)
);

// File: tb/brk_uart_rx_tb.sv
module brk_uart_rx_tb;

  localparam int CLK_HZ = 614400;
  localparam int BIT_F  = 64;
  localparam int BIT_S  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic        baud_fast = 1'b1;
  logic        err_clr = 1'b0;
  logic [7:0]  byte_o;
  logic        byte_vld;
  logic [23:0] pkt_o;
  logic        pkt_vld;
  logic        brk_o;
  logic        err_sticky;

  always #10 clk = ~clk;

  brk_uart_rx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_fast(baud_fast), .err_clr(err_clr),
    .byte_o(byte_o), .byte_vld(byte_vld), .pkt_o(pkt_o), .pkt_vld(pkt_vld),
    .brk_o(brk_o), .err_sticky(err_sticky)
  );

  int n_chk = 0, n_fail = 0, brk_exp = 0, cnt = 0, bp = BIT_F;
  bit armed = 0, err_exp = 0, done = 0;
  logic [23:0] acc = '0;
  logic [7:0]  qb[$];
  logic [23:0] qp[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (byte_vld) begin
      if (qb.size() == 0) chk(0, "R2", "unexpected byte", {24'd0, byte_o}, 0);
      else begin
        logic [7:0] e;
        e = qb.pop_front();
        chk(byte_o == e, "R2", "byte value", {24'd0, byte_o}, {24'd0, e});
      end
    end
    if (pkt_vld) begin
      if (qp.size() == 0) chk(0, "R5", "unexpected packet", {8'd0, pkt_o}, 0);
      else begin
        logic [23:0] e;
        e = qp.pop_front();
        chk(pkt_o == e, "R5", "packet value", {8'd0, pkt_o}, {8'd0, e});
      end
    end
    if (brk_o) begin
      chk(brk_exp > 0, "R4", "unexpected break strobe", 1, 0);
      if (brk_exp > 0) brk_exp--;
    end
  end

  task automatic tx_frame(input logic [10:0] fr);
    for (int i = 0; i < 11; i++) begin
      rxd = fr[i];
      repeat (bp) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (3 * bp) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit par_ok, input bit stp_ok);
    logic par;
    par = ~(^d) ^ !par_ok;
    if (!par_ok || !stp_ok) begin
      err_exp = 1;
      armed = 0;
    end else begin
      qb.push_back(d);
      if (baud_fast && armed) begin
        acc = {acc[15:0], d};
        cnt++;
        if (cnt == 3) begin
          qp.push_back(acc);
          armed = 0;
        end
      end
    end
    tx_frame({stp_ok, par, d, 1'b0});
  endtask

  task automatic send_brk();
    if (baud_fast) begin
      brk_exp++;
      armed = 1;
      cnt = 0;
    end else begin
      err_exp = 1;
      armed = 0;
    end
    tx_frame(11'd0);
  endtask

  task automatic settle(input string req);
    chk(qb.size() == 0, req, "bytes missing", qb.size(), 0);
    chk(qp.size() == 0, req, "packets missing", qp.size(), 0);
    chk(brk_exp == 0, req, "breaks missing", brk_exp, 0);
    chk(err_sticky == err_exp, req, "sticky error", err_sticky, err_exp);
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    err_exp = 0;
    @(negedge clk);
    chk(err_sticky == 1'b0, "R8", "error after clear", err_sticky, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    chk({byte_vld, pkt_vld, brk_o, err_sticky} == 4'b0, "R1", "strobes in reset",
        {byte_vld, pkt_vld, brk_o, err_sticky}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(byte_o == 8'd0 && pkt_o == 24'd0, "R1", "data after reset", {pkt_o, byte_o}, 0);
    chk(err_sticky == 1'b0, "R1", "error after reset", err_sticky, 0);
    repeat (2 * bp) @(negedge clk);

    send_brk(); send(8'h11, 1, 1); send(8'hA5, 1, 1); send(8'h3C, 1, 1);
    settle("R5");

    send(8'h80, 1, 1); send(8'h01, 1, 1);
    settle("R2");

    send_brk(); send(8'h44, 1, 1);
    send_brk(); send(8'h55, 1, 1); send(8'h66, 1, 1); send(8'h77, 1, 1);
    settle("R6");

    send_brk(); send(8'h12, 1, 1); send(8'h34, 0, 1); send(8'h56, 1, 1); send(8'h78, 1, 1);
    settle("R7");
    chk(err_sticky == 1'b1, "R8", "error held", err_sticky, 1);
    clear_err();

    send_brk(); send(8'h9A, 1, 1); send(8'hBC, 1, 0); send(8'hDE, 1, 1); send(8'hF0, 1, 1);
    settle("R7");
    clear_err();

    send_brk();
    settle("R4");

    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bp) @(negedge clk);
    chk(!byte_vld && !brk_o, "R3", "glitch output", {byte_vld, brk_o}, 0);
    settle("R3");

    baud_fast = 1'b0;
    bp = BIT_S;
    repeat (bp) @(negedge clk);
    send(8'h5A, 1, 1);
    send_brk();
    settle("R9");
    clear_err();
    send(8'hC3, 1, 1); send(8'h0F, 1, 1); send(8'hE1, 1, 1);
    settle("R9");

    baud_fast = 1'b1;
    bp = BIT_F;
    repeat (bp) @(negedge clk);
    send_brk(); send(8'h2B, 1, 1); send(8'hFF, 1, 1); send(8'h00, 1, 1);
    settle("R10");

    finish_run();
  end

endmodule